// File: doc/BRIEF.md
# Serial Debug Probe Address Chain

This block lets a debug host look at any one of a grid of internal node outputs, on up to two observation pins at once, through a narrow serial link. The host raises a qualifying enable, then clocks in one frame of bits on a serial data line, one bit per rising edge of the debug clock. A frame is a fixed-length chain: an unlock key, a 21-bit mode word, a run of filler, then one-hot row and column fields for each of the two probe channels, and a closing stop bit.

Each probe channel is used only after a frame is complete. The stop bit must arrive, and the key and mode word must carry accepted values. When that happens, the block stores the row and column selections and the enable for each channel. Each probe pin then follows the selected node live until a later valid frame replaces the selection. A security input forces both probe pins low while it is asserted.

Grid rows, grid columns, filler length and the key are all parameters. The defaults are small so that simulation is quick.

Top module: `dbg_probe_chain`

## Requirements
- R1: During and after reset, with no frame yet accepted, both probe outputs are 0 whatever the node values are.
- R2: Bits are taken only on rising edges of `dclk` while `modeEn` is high. Dropping `modeEn` restarts the frame position at bit 0. An incomplete frame never changes the probe selection.
- R3: Frame bit order, first bit first: the key with its leftmost bit first; the 21-bit mode word with its leftmost bit first; FILL_LEN filler bits whose values are ignored; the channel-B row field (ROWS bits); the channel-B column field (COLS bits); the channel-A row field (ROWS bits); the channel-A column field (COLS bits); the stop bit. Every field is sent index 0 first. The frame length is 31 + FILL_LEN + 2·ROWS + 2·COLS + 1 bits.
- R4: A valid frame takes effect on the clock edge that captures its stop bit, and not on any earlier edge.
- R5: A frame whose key differs from KEY_PATTERN (default 0011011111) leaves the previous selection unchanged.
- R6: Only three mode words are accepted. 000000110001111100000 enables channel A only. 000000101001111100000 enables channel B only. 000000111001111100000 enables both. Any other mode word leaves the previous selection unchanged. A channel that is not enabled drives 0.
- R7: `probeA` shows node `nodeVals[row*COLS+col]` for the channel-A fields. `probeB` shows the node for the channel-B fields.
- R8: If a channel's row field or column field is not exactly one-hot, that channel drives 0.
- R9: While `secureLock` is high, both probe outputs are 0. Frames are still accepted during the lock, and their selection appears once the lock is released.
- R10: After the stop bit, further bits are ignored until `modeEn` has gone low.
- R11: A probe output follows changes of the selected node combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Debug shift clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| modeEn | input | 1 | Qualifies shifting; low resets the frame position |
| sdi | input | 1 | Serial frame data |
| secureLock | input | 1 | High blocks both probe outputs |
| nodeVals | input | ROWS*COLS | Flattened node outputs, index row*COLS+col |
| probeA | output | 1 | Channel A observation output |
| probeB | output | 1 | Channel B observation output |

## Verification
The cases that are hardest to reach from the ports sit at the frame edge: the stop-bit cycle itself, and bits that keep arriving after the stop bit with `modeEn` still high. To reach the first, the bench stops just after driving the stop bit and samples before and after that edge. The node pattern is chosen so that the old and the new selection give different values. To reach the second, the bench sends a second complete frame back-to-back without lowering `modeEn`. Every row/column pair of the small grid is also loaded. Each pair is checked under four node patterns, with the two channels set to different nodes so that any swap of fields or bit order is exposed.

// File: rtl/dbg_probe_pkg.sv
package dbg_probe_pkg;

  localparam int KEY_LEN  = 10;
  localparam int MODE_LEN = 21;

  localparam logic [MODE_LEN-1:0] MODE_ONLY_A = 21'b000000110001111100000;
  localparam logic [MODE_LEN-1:0] MODE_ONLY_B = 21'b000000101001111100000;
  localparam logic [MODE_LEN-1:0] MODE_BOTH   = 21'b000000111001111100000;

  // strobes from the frame sequencer to the datapath
  typedef struct packed {
    logic shift;   // capture one payload bit
    logic commit;  // this edge carries the stop bit
  } probeStb_t;

endpackage

// File: rtl/dbg_probe_ctrl.sv
module dbg_probe_ctrl
  import dbg_probe_pkg::*;
#(
  parameter int STREAM_LEN = 53
) (
  input  logic      dclk,
  input  logic      rstN,
  input  logic      modeEn,
  output probeStb_t stb
);

  localparam int POS_W = $clog2(STREAM_LEN + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(STREAM_LEN - 1);
  localparam logic [POS_W-1:0] DONE_POS = POS_W'(STREAM_LEN);

  logic [POS_W-1:0] bitPos;

  // position in the frame; parks at DONE_POS after the stop bit
  always_ff @(posedge dclk or negedge rstN) begin
    if (!rstN) begin
      bitPos <= '0;
    end else if (!modeEn) begin
      bitPos <= '0;
    end else if (bitPos != DONE_POS) begin
      bitPos <= bitPos + 1'b1;
    end
  end

  always_comb begin
    stb.shift  = modeEn && (bitPos < LAST_POS);
    stb.commit = modeEn && (bitPos == LAST_POS);
  end

endmodule

// File: rtl/dbg_probe_dpath.sv
module dbg_probe_dpath
  import dbg_probe_pkg::*;
#(
  parameter int              ROWS        = 4,
  parameter int              COLS        = 5,
  parameter int              FILL_LEN    = 3,
  parameter logic [KEY_LEN-1:0] KEY_PATTERN = 10'b0011011111
) (
  input  logic                 dclk,
  input  logic                 rstN,
  input  logic                 sdi,
  input  probeStb_t            stb,
  output logic                 load,
  output logic [1:0]           chanEn,
  output logic [1:0][ROWS-1:0] rowHot,
  output logic [1:0][COLS-1:0] colHot
);

  localparam int PAY     = KEY_LEN + MODE_LEN + FILL_LEN + 2*ROWS + 2*COLS;
  localparam int BASE_X2 = KEY_LEN + MODE_LEN + FILL_LEN;
  localparam int BASE_Y2 = BASE_X2 + ROWS;
  localparam int BASE_X1 = BASE_Y2 + COLS;
  localparam int BASE_Y1 = BASE_X1 + ROWS;

  // oldest bit ends up at the top
  logic [PAY-1:0]      shiftReg;
  logic [KEY_LEN-1:0]  keyField;
  logic [MODE_LEN-1:0] modeField;
  logic                keyOk;
  logic                modeOk;
  logic [1:0]          modeEn2;

  always_ff @(posedge dclk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.shift) begin
      shiftReg <= {shiftReg[PAY-2:0], sdi};
    end
  end

  assign keyField  = shiftReg[PAY-1 -: KEY_LEN];
  assign modeField = shiftReg[PAY-1-KEY_LEN -: MODE_LEN];

  // frame order k lands at shiftReg[PAY-1-k]; channel 0 = A, 1 = B
  for (genvar i = 0; i < ROWS; i++) begin : g_rowTap
    assign rowHot[1][i] = shiftReg[PAY-1-(BASE_X2+i)];
    assign rowHot[0][i] = shiftReg[PAY-1-(BASE_X1+i)];
  end

  for (genvar j = 0; j < COLS; j++) begin : g_colTap
    assign colHot[1][j] = shiftReg[PAY-1-(BASE_Y2+j)];
    assign colHot[0][j] = shiftReg[PAY-1-(BASE_Y1+j)];
  end

  always_comb begin
    keyOk = (keyField == KEY_PATTERN);
    unique case (modeField)
      MODE_ONLY_A: begin modeOk = 1'b1; modeEn2 = 2'b01; end
      MODE_ONLY_B: begin modeOk = 1'b1; modeEn2 = 2'b10; end
      MODE_BOTH:   begin modeOk = 1'b1; modeEn2 = 2'b11; end
      default:     begin modeOk = 1'b0; modeEn2 = 2'b00; end
    endcase
    load   = stb.commit && keyOk && modeOk;
    chanEn = modeEn2;
  end

endmodule

// File: rtl/dbg_probe_tap.sv
module dbg_probe_tap #(
  parameter int ROWS = 4,
  parameter int COLS = 5
) (
  input  logic                 dclk,
  input  logic                 rstN,
  input  logic                 load,
  input  logic                 enNext,
  input  logic [ROWS-1:0]      rowHot,
  input  logic [COLS-1:0]      colHot,
  input  logic [ROWS*COLS-1:0] nodeVals,
  input  logic                 block,
  output logic                 probeOut
);

  localparam int NODES  = ROWS * COLS;
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1;

  logic [ROW_W-1:0]  rowIdx;
  logic [COL_W-1:0]  colIdx;
  logic [NODE_W-1:0] flatNext;
  logic              fieldOk;

  logic              tapEn;
  logic              tapOk;
  logic [NODE_W-1:0] flatIdx;

  always_comb begin
    rowIdx = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (rowHot[i]) rowIdx = ROW_W'(i);
    end
    colIdx = '0;
    for (int j = 0; j < COLS; j++) begin
      if (colHot[j]) colIdx = COL_W'(j);
    end
    fieldOk  = $onehot(rowHot) && $onehot(colHot);
    flatNext = NODE_W'(rowIdx) * NODE_W'(COLS) + NODE_W'(colIdx);
  end

  always_ff @(posedge dclk or negedge rstN) begin
    if (!rstN) begin
      tapEn   <= 1'b0;
      tapOk   <= 1'b0;
      flatIdx <= '0;
    end else if (load) begin
      tapEn   <= enNext;
      tapOk   <= fieldOk;
      flatIdx <= flatNext;
    end
  end

  assign probeOut = tapEn && tapOk && !block && nodeVals[flatIdx];

endmodule

// File: rtl/dbg_probe_chain.sv
module dbg_probe_chain
  import dbg_probe_pkg::*;
#(
  parameter int                 ROWS        = 4,
  parameter int                 COLS        = 5,
  parameter int                 FILL_LEN    = 3,
  parameter logic [KEY_LEN-1:0] KEY_PATTERN = 10'b0011011111
) (
  input  logic                 dclk,
  input  logic                 rstN,
  input  logic                 modeEn,
  input  logic                 sdi,
  input  logic                 secureLock,
  input  logic [ROWS*COLS-1:0] nodeVals,
  output logic                 probeA,
  output logic                 probeB
);

  localparam int STREAM_LEN = KEY_LEN + MODE_LEN + FILL_LEN + 2*ROWS + 2*COLS + 1;

  probeStb_t           ctrlStb;
  logic                loadSel;
  logic [1:0]          chanEn;
  logic [1:0][ROWS-1:0] rowHot;
  logic [1:0][COLS-1:0] colHot;
  logic [1:0]          probeVec;

  dbg_probe_ctrl #(.STREAM_LEN(STREAM_LEN)) u_ctrl (
    .dclk   (dclk),
    .rstN   (rstN),
    .modeEn (modeEn),
    .stb    (ctrlStb)
  );

  dbg_probe_dpath #(
    .ROWS(ROWS), .COLS(COLS), .FILL_LEN(FILL_LEN), .KEY_PATTERN(KEY_PATTERN)
  ) u_dpath (
    .dclk   (dclk),
    .rstN   (rstN),
    .sdi    (sdi),
    .stb    (ctrlStb),
    .load   (loadSel),
    .chanEn (chanEn),
    .rowHot (rowHot),
    .colHot (colHot)
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_tap
    dbg_probe_tap #(.ROWS(ROWS), .COLS(COLS)) u_tap (
      .dclk     (dclk),
      .rstN     (rstN),
      .load     (loadSel),
      .enNext   (chanEn[ch]),
      .rowHot   (rowHot[ch]),
      .colHot   (colHot[ch]),
      .nodeVals (nodeVals),
      .block    (secureLock),
      .probeOut (probeVec[ch])
    );
  end

  assign probeA = probeVec[0];
  assign probeB = probeVec[1];

endmodule

// File: rtl/dbg_probe_chk.sv
module dbg_probe_chk #(
  parameter int NODES = 20
) (
  input logic             dclk,
  input logic             rstN,
  input logic             modeEn,
  input logic             secureLock,
  input logic [NODES-1:0] nodeVals,
  input logic             probeA,
  input logic             probeB,
  input logic             commitStb
);

  // R9
  secure_block_chk: assert property (@(posedge dclk) disable iff (!rstN)
    secureLock |-> (!probeA && !probeB));

  // R4
  hold_sel_chk: assert property (@(posedge dclk) disable iff (!rstN)
    (!$past(commitStb) && $stable(nodeVals) && $stable(secureLock))
      |-> ($stable(probeA) && $stable(probeB)));

  // R2
  mode_low_chk: assert property (@(posedge dclk) disable iff (!rstN)
    !modeEn |=> !commitStb);

  // R10
  single_commit_chk: assert property (@(posedge dclk) disable iff (!rstN)
    commitStb |=> !commitStb);

endmodule

bind dbg_probe_chain dbg_probe_chk #(.NODES(ROWS*COLS)) u_chk (
  .dclk       (dclk),
  .rstN       (rstN),
  .modeEn     (modeEn),
  .secureLock (secureLock),
  .nodeVals   (nodeVals),
  .probeA     (probeA),
  .probeB     (probeB),
  .commitStb  (ctrlStb.commit)
);

// File: tb/dbg_probe_chain_tb.sv
module dbg_probe_chain_tb;
  import dbg_probe_pkg::*;

  localparam int ROWS  = 4;
  localparam int COLS  = 5;
  localparam int FILL  = 3;
  localparam int NODES = ROWS * COLS;
  localparam int TOTAL = 10 + 21 + FILL + 2*ROWS + 2*COLS + 1;
  localparam logic [9:0] KEY = 10'b0011011111;

  logic dclk = 1'b0;
  always #4 dclk = ~dclk;

  logic             rstN = 1'b0;
  logic             modeEn = 1'b0;
  logic             sdi = 1'b0;
  logic             secureLock = 1'b0;
  logic [NODES-1:0] nodeVals = '0;
  logic             probeA;
  logic             probeB;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  dbg_probe_chain #(.ROWS(ROWS), .COLS(COLS), .FILL_LEN(FILL)) u_dut (
    .dclk(dclk), .rstN(rstN), .modeEn(modeEn), .sdi(sdi),
    .secureLock(secureLock), .nodeVals(nodeVals),
    .probeA(probeA), .probeB(probeB)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [ROWS-1:0] rHot(input int i);
    rHot = '0;
    rHot[i] = 1'b1;
  endfunction

  function automatic logic [COLS-1:0] cHot(input int j);
    cHot = '0;
    cHot[j] = 1'b1;
  endfunction

  function automatic logic [NODES-1:0] nHot(input int n);
    nHot = '0;
    nHot[n] = 1'b1;
  endfunction

  // drives the first nBits of a frame, one per negedge, modeEn held high
  task automatic sendBits(input logic [9:0] k, input logic [20:0] m,
                          input logic [ROWS-1:0] x1, input logic [COLS-1:0] y1,
                          input logic [ROWS-1:0] x2, input logic [COLS-1:0] y2,
                          input int nBits);
    logic [TOTAL-1:0] s;
    int p;
    s = '0;
    p = 0;
    for (int i = 0; i < 10; i++) begin s[p] = k[9-i]; p = p + 1; end
    for (int i = 0; i < 21; i++) begin s[p] = m[20-i]; p = p + 1; end
    for (int i = 0; i < FILL; i++) begin s[p] = 1'b0; p = p + 1; end
    for (int i = 0; i < ROWS; i++) begin s[p] = x2[i]; p = p + 1; end
    for (int i = 0; i < COLS; i++) begin s[p] = y2[i]; p = p + 1; end
    for (int i = 0; i < ROWS; i++) begin s[p] = x1[i]; p = p + 1; end
    for (int i = 0; i < COLS; i++) begin s[p] = y1[i]; p = p + 1; end
    s[p] = 1'b1;
    for (int b = 0; b < nBits; b++) begin
      @(negedge dclk);
      modeEn = 1'b1;
      sdi = s[b];
    end
  endtask

  task automatic endStream();
    @(negedge dclk);
    modeEn = 1'b0;
    sdi = 1'b0;
    #1;
  endtask

  task automatic loadFrame(input logic [9:0] k, input logic [20:0] m,
                           input logic [ROWS-1:0] x1, input logic [COLS-1:0] y1,
                           input logic [ROWS-1:0] x2, input logic [COLS-1:0] y2);
    sendBits(k, m, x1, y1, x2, y2, TOTAL);
    endStream();
  endtask

  initial begin
    repeat (200000) @(posedge dclk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    nodeVals = '1;
    repeat (3) @(negedge dclk);
    #1;
    check("R1 probeA in reset", probeA, 1'b0);
    check("R1 probeB in reset", probeB, 1'b0);
    @(negedge dclk);
    rstN = 1'b1;
    repeat (3) @(negedge dclk);
    #1;
    check("R1 probeA after reset", probeA, 1'b0);
    check("R1 probeB after reset", probeB, 1'b0);

    // R3 R7 R11 sweep of every A position, B offset
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int rb;
        int cb;
        rb = (r + 1) % ROWS;
        cb = (c + 2) % COLS;
        loadFrame(KEY, MODE_BOTH, rHot(r), cHot(c), rHot(rb), cHot(cb));
        for (int pat = 0; pat < 4; pat++) begin
          case (pat)
            0: nodeVals = nHot(r*COLS + c);
            1: nodeVals = nHot(rb*COLS + cb);
            2: nodeVals = '1;
            default: nodeVals = '0;
          endcase
          #1;
          check("R3 R7 R11 probeA sweep", probeA, nodeVals[r*COLS + c]);
          check("R3 R7 R11 probeB sweep", probeB, nodeVals[rb*COLS + cb]);
        end
      end
    end

    // R4 stop-bit edge; previous A node is 19
    nodeVals = nHot(19);
    sendBits(KEY, MODE_BOTH, rHot(0), cHot(0), rHot(1), cHot(1), TOTAL);
    #1;
    check("R4 old selection before stop edge", probeA, 1'b1);
    endStream();
    check("R4 new selection after stop edge", probeA, 1'b0);
    nodeVals = nHot(0);
    #1;
    check("R4 new A node visible", probeA, 1'b1);

    // R6 mode words
    nodeVals = '1;
    loadFrame(KEY, MODE_ONLY_A, rHot(1), cHot(2), rHot(2), cHot(3));
    check("R6 A-only probeA", probeA, 1'b1);
    check("R6 A-only probeB", probeB, 1'b0);
    loadFrame(KEY, MODE_ONLY_B, rHot(1), cHot(2), rHot(2), cHot(3));
    check("R6 B-only probeA", probeA, 1'b0);
    check("R6 B-only probeB", probeB, 1'b1);
    loadFrame(KEY, 21'b000000100001111100000, rHot(0), cHot(0), rHot(0), cHot(0));
    nodeVals = nHot(13);
    #1;
    check("R6 bad mode keeps B", probeB, 1'b1);
    check("R6 bad mode keeps A off", probeA, 1'b0);
    nodeVals = nHot(0);
    #1;
    check("R6 bad mode not applied", probeB, 1'b0);

    // R5 key mismatch
    loadFrame(KEY, MODE_BOTH, rHot(1), cHot(1), rHot(2), cHot(2));
    loadFrame(KEY ^ 10'h001, MODE_BOTH, rHot(3), cHot(3), rHot(0), cHot(0));
    nodeVals = nHot(6);
    #1;
    check("R5 bad key keeps A", probeA, 1'b1);
    nodeVals = nHot(18);
    #1;
    check("R5 bad key not applied A", probeA, 1'b0);
    nodeVals = nHot(12);
    #1;
    check("R5 bad key keeps B", probeB, 1'b1);

    // R8 malformed one-hot fields
    nodeVals = '1;
    loadFrame(KEY, MODE_BOTH, 4'b0011, cHot(1), rHot(2), cHot(2));
    check("R8 two-hot row A", probeA, 1'b0);
    check("R8 good B alongside", probeB, 1'b1);
    loadFrame(KEY, MODE_BOTH, rHot(0), cHot(0), '0, cHot(0));
    check("R8 good A alongside", probeA, 1'b1);
    check("R8 zero row B", probeB, 1'b0);
    loadFrame(KEY, MODE_BOTH, rHot(0), '0, rHot(1), 5'b10001);
    check("R8 zero col A", probeA, 1'b0);
    check("R8 two-hot col B", probeB, 1'b0);

    // R9 security lock
    loadFrame(KEY, MODE_BOTH, rHot(1), cHot(0), rHot(2), cHot(4));
    secureLock = 1'b1;
    #1;
    check("R9 lock blocks A", probeA, 1'b0);
    check("R9 lock blocks B", probeB, 1'b0);
    nodeVals = nHot(0);
    loadFrame(KEY, MODE_BOTH, rHot(0), cHot(0), rHot(0), cHot(0));
    check("R9 lock blocks A after frame", probeA, 1'b0);
    secureLock = 1'b0;
    #1;
    check("R9 frame under lock applied A", probeA, 1'b1);
    check("R9 frame under lock applied B", probeB, 1'b1);

    // R10 bits after stop ignored while modeEn stays high
    sendBits(KEY, MODE_BOTH, rHot(2), cHot(1), rHot(2), cHot(1), TOTAL);
    sendBits(KEY, MODE_BOTH, rHot(3), cHot(4), rHot(3), cHot(4), TOTAL);
    endStream();
    nodeVals = nHot(11);
    #1;
    check("R10 first frame kept A", probeA, 1'b1);
    check("R10 first frame kept B", probeB, 1'b1);
    nodeVals = nHot(19);
    #1;
    check("R10 trailing frame ignored", probeA, 1'b0);

    // R2 partial frames and mode qualification
    sendBits(KEY, MODE_BOTH, rHot(0), cHot(3), rHot(0), cHot(3), 30);
    endStream();
    nodeVals = nHot(11);
    #1;
    check("R2 partial frame no change", probeA, 1'b1);
    for (int t = 0; t < TOTAL + 4; t++) begin
      @(negedge dclk);
      sdi = t[0];
    end
    sdi = 1'b0;
    #1;
    check("R2 mode low shifting ignored", probeA, 1'b1);
    sendBits(KEY, MODE_BOTH, rHot(0), cHot(3), rHot(0), cHot(3), TOTAL - 1);
    endStream();
    #1;
    check("R2 frame missing stop bit", probeA, 1'b1);
    sendBits(KEY, MODE_BOTH, rHot(1), cHot(1), rHot(1), cHot(1), 40);
    endStream();
    loadFrame(KEY, MODE_BOTH, rHot(2), cHot(2), rHot(2), cHot(2));
    nodeVals = nHot(12);
    #1;
    check("R2 restart after drop A", probeA, 1'b1);
    check("R2 restart after drop B", probeB, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule